// File: doc/BRIEF.md
# Systematic Rate-1/2 LDPC Block Encoder

This block turns an 8-bit message into a 16-bit codeword of a rate-1/2 low-density parity-check code. The code is systematic. The message goes out unchanged in the upper half of the codeword. Each bit of the lower half is a modulo-2 sum of message bits. Each sum is set by one row of an 8x8 parity sub-matrix. That sub-matrix comes from a sparse 8x16 check matrix that was brought to the form [parity part | identity] by modulo-2 row operations and swaps. It is supplied as a 64-bit compile-time parameter. The hardware does not derive it.

A message is offered with a one-cycle valid strobe, and a new message may be offered on every clock. The codeword is registered and appears with its valid flag one clock after the strobe is sampled. That gives one codeword per cycle.

A small two-state machine tracks whether the output register holds a codeword from the previous cycle. It has two states. ST_IDLE means no codeword was issued on the last edge. ST_EMIT means a codeword was issued on the last edge. From either state, a sampled strobe moves to ST_EMIT and a cycle without a strobe moves to ST_IDLE. Reset forces ST_IDLE.

Top module: `ldpc_sys_encoder`

## Requirements
- R1: While rst is high at a clock edge, cw_bits becomes all zeros and cw_valid becomes 0 after that edge.
- R2: One clock after msg_valid is sampled high, cw_bits[15:8] equals the msg_bits value sampled at that edge, bit for bit.
- R3: One clock after msg_valid is sampled high, cw_bits[j] for j in 0..7 equals the XOR of every msg_bits[i] for which PAR_MASKS[8*j+i] is 1.
- R4: cw_valid is 1 exactly in the cycle after an edge where msg_valid was sampled high, and 0 after an edge where it was sampled low.
- R5: Messages strobed on consecutive clocks each produce their own codeword on consecutive clocks, with no gap and no stall.
- R6: After an edge where msg_valid is sampled low, cw_bits keeps its previous value, whatever msg_bits carries.
- R7: With the default PAR_MASKS (64'hA4C8_C4D0_2A94_490B), message 8'b00110111 encodes to 16'b0011011100110010.
- R8: Every valid codeword has a zero syndrome against the check matrix. Row j of that matrix covers codeword bit 8+i where PAR_MASKS[8*j+i] is 1, and also covers codeword bit j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message strobe, sampled each rising edge |
| msg_bits | input | MSG_W (8) | Message word |
| cw_valid | output | 1 | Codeword valid, one clock after the strobe |
| cw_bits | output | 2*MSG_W (16) | Codeword: message in the upper half, parity in the lower half |

## Verification
The all-zero message checks that no parity bit has a constant term. Walking single-bit messages expose each column of the parity sub-matrix separately, so a wrong or swapped mask bit shows up in the parity bit it affects. The all-ones message and the example message 00110111 test the full XOR sums. A back-to-back stream from a shift-register sequence separates one-per-cycle throughput from designs that stall or skip. Idle gaps where the message input keeps changing separate a held codeword from one that follows the input. A reset in the middle of the stream confirms that the output clears even while a strobe is present.

// File: rtl/ldpc_enc_pkg.sv
package ldpc_enc_pkg;

    // Output-register occupancy state
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } enc_state_e;

    localparam int unsigned MSG_W_DEFAULT = 8;

endpackage

// File: rtl/ldpc_parity_net.sv
module ldpc_parity_net #(
    parameter int unsigned MSG_W     = 8,
    parameter logic [MSG_W*MSG_W-1:0] PAR_MASKS = 64'hA4C8_C4D0_2A94_490B
) (
    input  logic [MSG_W-1:0] msg,
    output logic [MSG_W-1:0] parity
);

    // One XOR tree per parity bit, selected by its mask row
    for (genvar j = 0; j < MSG_W; j++) begin : g_par
        localparam logic [MSG_W-1:0] ROW = PAR_MASKS[j*MSG_W +: MSG_W];
        assign parity[j] = ^(msg & ROW);
    end

endmodule

// File: rtl/ldpc_enc_fsm.sv
module ldpc_enc_fsm
    import ldpc_enc_pkg::*;
#(
    parameter int unsigned CW_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [CW_W-1:0] cw_next,
    output logic [CW_W-1:0] cw_q,
    output logic            valid_q
);

    enc_state_e state_q;
    enc_state_e state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_nxt = take ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nxt = take ? ST_EMIT : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Codeword register: loads on a strobe, holds otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            cw_q <= '0;
        end else if (take) begin
            cw_q <= cw_next;
        end
    end

    // Output flag decoded from state
    always_comb begin
        valid_q = 1'b0;
        unique case (state_q)
            ST_IDLE: valid_q = 1'b0;
            ST_EMIT: valid_q = 1'b1;
            default: valid_q = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldpc_sys_encoder.sv
module ldpc_sys_encoder #(
    parameter int unsigned MSG_W = 8,
    parameter logic [MSG_W*MSG_W-1:0] PAR_MASKS = 64'hA4C8_C4D0_2A94_490B
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               msg_valid,
    input  logic [MSG_W-1:0]   msg_bits,
    output logic               cw_valid,
    output logic [2*MSG_W-1:0] cw_bits
);

    localparam int unsigned CW_W = 2 * MSG_W;

    logic [MSG_W-1:0] parity;
    logic [CW_W-1:0]  cw_comb;

    ldpc_parity_net #(
        .MSG_W     (MSG_W),
        .PAR_MASKS (PAR_MASKS)
    ) u_par (
        .msg    (msg_bits),
        .parity (parity)
    );

    assign cw_comb = {msg_bits, parity};

    ldpc_enc_fsm #(
        .CW_W (CW_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .take    (msg_valid),
        .cw_next (cw_comb),
        .cw_q    (cw_bits),
        .valid_q (cw_valid)
    );

endmodule

// File: rtl/ldpc_sys_encoder_chk.sv
module ldpc_sys_encoder_chk #(
    parameter int unsigned MSG_W = 8,
    parameter logic [MSG_W*MSG_W-1:0] PAR_MASKS = 64'hA4C8_C4D0_2A94_490B
) (
    input logic               clk,
    input logic               rst,
    input logic               msg_valid,
    input logic [MSG_W-1:0]   msg_bits,
    input logic               cw_valid,
    input logic [2*MSG_W-1:0] cw_bits
);

    // Syndrome of the registered codeword against the check matrix
    logic [MSG_W-1:0] synd;
    always_comb begin
        for (int j = 0; j < MSG_W; j++) begin
            synd[j] = (^(cw_bits[2*MSG_W-1:MSG_W] & PAR_MASKS[j*MSG_W +: MSG_W])) ^ cw_bits[j];
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cw_bits == '0) && !cw_valid);

    p_sys_copy_r2: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> cw_bits[2*MSG_W-1:MSG_W] == $past(msg_bits));

    p_valid_follow_r4: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> cw_valid);

    p_valid_drop_r4: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |=> !cw_valid);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |=> $stable(cw_bits));

    p_syndrome_r8: assert property (@(posedge clk) disable iff (rst)
        cw_valid |-> synd == '0);

endmodule

bind ldpc_sys_encoder ldpc_sys_encoder_chk #(
    .MSG_W     (MSG_W),
    .PAR_MASKS (PAR_MASKS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg_bits  (msg_bits),
    .cw_valid  (cw_valid),
    .cw_bits   (cw_bits)
);

// File: tb/tb_ldpc_sys_encoder.sv
module tb_ldpc_sys_encoder;

    localparam int W = 8;
    localparam logic [63:0] MASKS = 64'hA4C8_C4D0_2A94_490B;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          msg_valid = 1'b0;
    logic [W-1:0]  msg_bits = '0;
    logic          cw_valid;
    logic [2*W-1:0] cw_bits;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ldpc_sys_encoder #(.MSG_W(W), .PAR_MASKS(MASKS)) dut (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_bits(msg_bits),
        .cw_valid(cw_valid), .cw_bits(cw_bits)
    );

    function automatic logic [15:0] ref_encode(input logic [7:0] m);
        logic [7:0] p;
        for (int j = 0; j < 8; j++) begin
            p[j] = 1'b0;
            for (int i = 0; i < 8; i++) begin
                if (MASKS[j*8+i] && m[i]) p[j] = ~p[j];
            end
        end
        return {m, p};
    endfunction

    function automatic bit syndrome_ok(input logic [15:0] c);
        for (int j = 0; j < 8; j++) begin
            logic [15:0] row;
            int ones;
            row = {MASKS[j*8 +: 8], 8'(1 << j)};
            ones = $countones(row & c);
            if (ones % 2 != 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [15:0] exp_cw;
    logic        exp_v;
    always @(posedge clk) begin
        if (rst) begin
            exp_cw <= '0;
            exp_v  <= 1'b0;
        end else begin
            exp_v <= msg_valid;
            if (msg_valid) exp_cw <= ref_encode(msg_bits);
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check(cw_bits[15:8] == exp_cw[15:8], "R2", {8'h0, cw_bits[15:8]}, {8'h0, exp_cw[15:8]});
            check(cw_bits[7:0] == exp_cw[7:0], "R3", {8'h0, cw_bits[7:0]}, {8'h0, exp_cw[7:0]});
            check(cw_valid == exp_v, "R4", {15'h0, cw_valid}, {15'h0, exp_v});
            if (cw_valid) check(syndrome_ok(cw_bits), "R8", cw_bits, 16'h0);
        end
    end

    task automatic send(input logic [7:0] m);
        msg_bits  = m;
        msg_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        logic [7:0] lfsr;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cw_bits == 16'h0 && !cw_valid, "R1", cw_bits, 16'h0);
        rst = 1'b0;
        @(negedge clk);

        // R7: example message
        send(8'b00110111);
        msg_valid = 1'b0;
        check(cw_bits == 16'b0011011100110010, "R7", cw_bits, 16'b0011011100110010);
        @(negedge clk);

        // R3: zero message, walking ones, all ones
        send(8'h00);
        check(cw_bits == 16'h0000, "R3", cw_bits, 16'h0000);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] col;
            send(8'(1 << i));
            for (int j = 0; j < 8; j++) col[j] = MASKS[j*8+i];
            check(cw_bits == {8'(1 << i), col}, "R3", cw_bits, {8'(1 << i), col});
        end
        send(8'hFF);
        check(cw_bits == ref_encode(8'hFF), "R3", cw_bits, ref_encode(8'hFF));

        // R5: back-to-back stream
        lfsr = 8'h5A;
        for (int n = 0; n < 40; n++) begin
            logic [7:0] cur;
            cur = lfsr;
            send(cur);
            check(cw_valid && cw_bits == ref_encode(cur), "R5", cw_bits, ref_encode(cur));
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end

        // R6: idle with moving input keeps codeword
        send(8'hC3);
        msg_valid = 1'b0;
        held = ref_encode(8'hC3);
        for (int n = 0; n < 4; n++) begin
            msg_bits = 8'(n * 37 + 5);
            @(negedge clk);
            check(cw_bits == held && !cw_valid, "R6", cw_bits, held);
        end

        // R1: reset mid-stream with strobe present
        send(8'h9E);
        rst = 1'b1;
        @(negedge clk);
        check(cw_bits == 16'h0 && !cw_valid, "R1", cw_bits, 16'h0);
        rst = 1'b0;
        msg_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule